// File: doc/BRIEF.md
# Trace Trigger Byte Countdown

This block holds the number of trace bytes that still have to be captured after a trigger has been seen. Software loads a 32-bit count through a simple 64-bit register port. Each cycle, the trace writer reports how many bytes it stored into the buffer. While the trigger-seen status flag is high and the count is nonzero, the block subtracts that number from the count.

When a subtraction brings a nonzero count down to zero, the block raises a single-cycle trigger-event pulse. The trace writer uses that pulse to stop capture. An alignment parameter makes the low bits of the count read-only zero, so software can only load multiples of the trace granule. Register writes are discarded while the trace buffer is enabled, because the count must not be disturbed during capture.

Top module: `trace_trig_counter`

## Requirements
- R1: `rd_data[63:32]` always reads zero, whatever was written to `wr_data[63:32]`.
- R2: While `trig_seen` is 1 and the count is nonzero, the count falls each cycle by `byte_cnt`, an unsigned value from 0 to MAX_BYTES.
- R3: A count of zero stays zero until software loads it again.
- R4: While `trig_seen` is 0, the count does not change unless a write is accepted.
- R5: The low ALIGN_BITS bits of `wr_data[31:0]` are discarded on a write. After any accepted write those bits read as zero.
- R6: A write is accepted only when `wr_en` is 1 and `buf_enable` is 0. With `buf_enable` at 1 the write is dropped, and counting continues as if no write had been presented.
- R7: When `byte_cnt` is greater than or equal to a nonzero count and counting is armed, the count becomes zero instead of wrapping.
- R8: `trig_event` is 1 for exactly the one cycle after the clock edge at which a decrement takes a nonzero count to zero. Loading zero by a write never raises it.
- R9: When a write is accepted in the same cycle as an armed decrement, the count takes the written value (masked as in R5) and `trig_event` stays 0.
- R10: Synchronous active-high `rst` sets the count to zero and `trig_event` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write data; only bits [31:0] are used |
| rd_data | output | 64 | Register read value; count in [31:0], zero above |
| buf_enable | input | 1 | Trace buffer enabled; blocks writes when 1 |
| trig_seen | input | 1 | Trigger-detected status flag; arms counting when 1 |
| byte_cnt | input | $clog2(MAX_BYTES+1) | Bytes stored into the buffer this cycle |
| trig_event | output | 1 | One-cycle pulse when counting reaches zero |

## Verification
The bench builds the block with ALIGN_BITS = 2 and MAX_BYTES = 8. With two masked bits, a write of an odd value or of all ones shows whether the low bits are really discarded. With eight bytes per cycle, the checks can reach the saturating step from a count of 2, the exact step from a count of 8, and counts that are not aligned after a decrement. The vectors also drive all-ones data into the upper half of every write, so every vector checks the zero upper word.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int CNT_W = 32;
    localparam int REG_W = 64;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_DEC  = 2'd2
    } upd_kind_t;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] value;
    } wr_req_t;

    typedef struct packed {
        logic             active;
        logic             hits_zero;
        logic [CNT_W-1:0] next;
    } dec_res_t;

    function automatic logic [CNT_W-1:0] align_mask(input int unsigned nbits);
        logic [CNT_W-1:0] low;
        low = (CNT_W'(1) << nbits) - CNT_W'(1);
        return ~low;
    endfunction

endpackage

// File: rtl/tbt_wr_gate.sv
module tbt_wr_gate #(
    parameter int unsigned ALIGN_BITS = 0
) (
    input  logic                      wr_en,
    input  logic [tbt_pkg::REG_W-1:0] wr_data,
    input  logic                      buf_enable,
    output tbt_pkg::wr_req_t          req
);
    localparam logic [tbt_pkg::CNT_W-1:0] MASK = tbt_pkg::align_mask(ALIGN_BITS);

    logic [tbt_pkg::REG_W-tbt_pkg::CNT_W-1:0] upper_unused;

    always_comb begin
        upper_unused = wr_data[tbt_pkg::REG_W-1:tbt_pkg::CNT_W];
        req.valid    = wr_en && !buf_enable;
        req.value    = wr_data[tbt_pkg::CNT_W-1:0] & MASK;
    end

    logic unused_ok;
    assign unused_ok = ^upper_unused;
endmodule

// File: rtl/tbt_dec_step.sv
module tbt_dec_step #(
    parameter int unsigned BYTES_W = 4
) (
    input  logic [tbt_pkg::CNT_W-1:0] cur,
    input  logic                      trig_seen,
    input  logic [BYTES_W-1:0]        byte_cnt,
    output tbt_pkg::dec_res_t         res
);
    localparam int unsigned PAD_W = tbt_pkg::CNT_W - BYTES_W;

    logic [tbt_pkg::CNT_W-1:0] bytes_ext;

    always_comb begin
        bytes_ext     = {{PAD_W{1'b0}}, byte_cnt};
        res.active    = trig_seen && (cur != '0);
        res.hits_zero = res.active && (cur <= bytes_ext);
        if (cur > bytes_ext) begin
            res.next = cur - bytes_ext;
        end else begin
            res.next = '0;
        end
    end
endmodule

// File: rtl/tbt_event_pulse.sv
module tbt_event_pulse (
    input  logic                 clk,
    input  logic                 rst,
    input  tbt_pkg::upd_kind_t   kind,
    input  logic                 hits_zero,
    output logic                 pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= (kind == tbt_pkg::UPD_DEC) && hits_zero;
        end
    end
endmodule

// File: rtl/trace_trig_counter.sv
module trace_trig_counter #(
    parameter int unsigned ALIGN_BITS = 0,
    parameter int unsigned MAX_BYTES  = 8,
    localparam int unsigned BYTES_W   = $clog2(MAX_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [tbt_pkg::REG_W-1:0] wr_data,
    output logic [tbt_pkg::REG_W-1:0] rd_data,
    input  logic                      buf_enable,
    input  logic                      trig_seen,
    input  logic [BYTES_W-1:0]        byte_cnt,
    output logic                      trig_event
);
    import tbt_pkg::*;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    wr_req_t          req;
    dec_res_t         dec;
    upd_kind_t        kind;

    tbt_wr_gate #(
        .ALIGN_BITS (ALIGN_BITS)
    ) u_gate (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .buf_enable (buf_enable),
        .req        (req)
    );

    tbt_dec_step #(
        .BYTES_W (BYTES_W)
    ) u_dec (
        .cur       (count_q),
        .trig_seen (trig_seen),
        .byte_cnt  (byte_cnt),
        .res       (dec)
    );

    always_comb begin
        if (req.valid) begin
            kind    = UPD_LOAD;
            count_d = req.value;
        end else if (dec.active) begin
            kind    = UPD_DEC;
            count_d = dec.next;
        end else begin
            kind    = UPD_HOLD;
            count_d = count_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    tbt_event_pulse u_evt (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .hits_zero (dec.hits_zero),
        .pulse     (trig_event)
    );

    assign rd_data = {{(REG_W-CNT_W){1'b0}}, count_q};
endmodule

// File: rtl/tbt_checker.sv
module tbt_checker #(
    parameter int unsigned ALIGN_BITS = 0,
    parameter int unsigned BYTES_W    = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [tbt_pkg::REG_W-1:0] wr_data,
    input logic [tbt_pkg::REG_W-1:0] rd_data,
    input logic                      buf_enable,
    input logic                      trig_seen,
    input logic [BYTES_W-1:0]        byte_cnt,
    input logic                      trig_event
);
    localparam logic [tbt_pkg::CNT_W-1:0] MASK = tbt_pkg::align_mask(ALIGN_BITS);

    logic                      load;
    logic [tbt_pkg::CNT_W-1:0] cnt;
    logic [tbt_pkg::CNT_W-1:0] bext;
    assign load = wr_en && !buf_enable;
    assign cnt  = rd_data[tbt_pkg::CNT_W-1:0];
    assign bext = tbt_pkg::CNT_W'(byte_cnt);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        rd_data[tbt_pkg::REG_W-1:tbt_pkg::CNT_W] == '0);

    assert_dec_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && trig_seen && cnt > bext) |=> cnt == $past(cnt) - $past(bext));

    assert_zero_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> cnt == '0);

    assert_unarmed_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !trig_seen) |=> $stable(rd_data));

    assert_low_bits_clear_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt & ~MASK) == '0);

    assert_locked_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && buf_enable && !trig_seen) |=> $stable(rd_data));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && trig_seen && cnt != '0 && cnt <= bext) |=> (cnt == '0 && trig_event));

    assert_event_single_R8: assert property (@(posedge clk) disable iff (rst)
        trig_event |=> !trig_event);

    assert_event_from_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        trig_event |-> (cnt == '0 && $past(cnt) != '0));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == ($past(wr_data[tbt_pkg::CNT_W-1:0]) & MASK) && !trig_event));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0 && !trig_event));
endmodule

bind trace_trig_counter tbt_checker #(
    .ALIGN_BITS (ALIGN_BITS),
    .BYTES_W    (BYTES_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .buf_enable (buf_enable),
    .trig_seen  (trig_seen),
    .byte_cnt   (byte_cnt),
    .trig_event (trig_event)
);

// File: tb/sim_trace_trig_counter.sv
module sim_trace_trig_counter;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned ALIGN_BITS = 2;
    localparam int unsigned MAX_BYTES  = 8;
    localparam int unsigned BW = $clog2(MAX_BYTES + 1);
    localparam int NVEC = 14;

    typedef struct packed {
        logic        wr;
        logic [31:0] wdata;
        logic        ben;
        logic        trig;
        logic [3:0]  bytes;
        logic [31:0] exp_cnt;
        logic        exp_evt;
        logic [7:0]  req;
    } vec_t;

    // req: requirement number the vector mainly targets
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'h0000_0013, 1'b0, 1'b0, 4'd0, 32'h0000_0010, 1'b0, 8'd5},
        '{1'b0, 32'h0,         1'b0, 1'b0, 4'd5, 32'h0000_0010, 1'b0, 8'd4},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd5, 32'h0000_000B, 1'b0, 8'd2},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd8, 32'h0000_0003, 1'b0, 8'd2},
        '{1'b1, 32'h0000_0040, 1'b1, 1'b1, 4'd1, 32'h0000_0002, 1'b0, 8'd6},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd8, 32'h0000_0000, 1'b1, 8'd7},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd3, 32'h0000_0000, 1'b0, 8'd3},
        '{1'b1, 32'h0000_0020, 1'b0, 1'b1, 4'd4, 32'h0000_0020, 1'b0, 8'd9},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd0, 32'h0000_0020, 1'b0, 8'd2},
        '{1'b1, 32'h0000_0000, 1'b0, 1'b1, 4'd0, 32'h0000_0000, 1'b0, 8'd8},
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'd0, 32'hFFFF_FFFC, 1'b0, 8'd5},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd4, 32'hFFFF_FFF8, 1'b0, 8'd2},
        '{1'b1, 32'h0000_0008, 1'b0, 1'b1, 4'd8, 32'h0000_0008, 1'b0, 8'd9},
        '{1'b0, 32'h0,         1'b0, 1'b1, 4'd8, 32'h0000_0000, 1'b1, 8'd8}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [63:0]   wr_data;
    logic [63:0]   rd_data;
    logic          buf_enable;
    logic          trig_seen;
    logic [BW-1:0] byte_cnt;
    logic          trig_event;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_trig_counter #(
        .ALIGN_BITS (ALIGN_BITS),
        .MAX_BYTES  (MAX_BYTES)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .buf_enable (buf_enable),
        .trig_seen  (trig_seen),
        .byte_cnt   (byte_cnt),
        .trig_event (trig_event)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [31:0] d, input logic be,
                         input logic tr, input logic [BW-1:0] b);
        wr_en      = w;
        wr_data    = {32'hFFFF_FFFF, d};
        buf_enable = be;
        trig_seen  = tr;
        byte_cnt   = b;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 32'h0, 1'b0, 1'b0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10 count", rd_data, 64'h0);
        check("R10 event", {63'h0, trig_event}, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].wr, VECS[i].wdata, VECS[i].ben, VECS[i].trig, BW'(VECS[i].bytes));
            @(negedge clk);
            check($sformatf("R%0d vec%0d count", VECS[i].req, i), {32'h0, rd_data[31:0]}, {32'h0, VECS[i].exp_cnt});
            check($sformatf("R%0d vec%0d event", VECS[i].req, i), {63'h0, trig_event}, {63'h0, VECS[i].exp_evt});
            // R1: upper word zero even with all-ones written there
            check($sformatf("R1 vec%0d upper", i), {32'h0, rd_data[63:32]}, 64'h0);
        end

        // R8: event lasts a single cycle
        drive(1'b0, 32'h0, 1'b0, 1'b1, '0);
        @(negedge clk);
        check("R8 pulse width", {63'h0, trig_event}, 64'h0);

        // R6: locked write with counting unarmed leaves count untouched
        drive(1'b1, 32'h0000_0100, 1'b1, 1'b0, '0);
        @(negedge clk);
        check("R6 locked", rd_data, 64'h0);

        // R10: reset in the middle of a count
        drive(1'b1, 32'h0000_0444, 1'b0, 1'b0, '0);
        @(negedge clk);
        check("R5 load 0x444", rd_data, 64'h0000_0000_0000_0444);
        drive(1'b0, 32'h0, 1'b0, 1'b1, BW'(3));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid reset", rd_data, 64'h0);
        check("R10 mid reset event", {63'h0, trig_event}, 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule